// File: doc/BRIEF.md
# Three-phase center-aligned PWM generator

This block drives the six gates of a three-phase inverter bridge: a high-side and a low-side output for each of the phases A, B and C. All three phases share one up/down timer. The timer counts up through half a switching period and then back down, so each phase's on-pulse is centred on the turnaround point. A simple write port loads the settings. These are the half-period count, a dead time, a narrow-pulse deletion width, the three duty values, a chopping-carrier divider and a control word. The control word holds output enables, per-phase high/low swap, high-side and low-side chopping, and the update mode.

For a clock f_clk and a switching frequency f_sw, software writes a half-period count of f_clk / (2 * f_sw). Edges are placed to one clock cycle. A 16-bit count reaches switching rates as low as f_clk / 131070. The timer stays stopped after reset until a duty register is written. From then on, a one-cycle sync pulse marks the start of every period. An external trip input forces all six gates off at once. They stay off until the control word is written again.

Top module: `pwm3_top`

## Requirements
- R1: After reset, all six gates and the sync pulse stay low while the timer is stopped. The timer starts only on the first write to a duty register (address 3, 4 or 5). Writes to other registers do not start it.
- R2: With half-period P (address 0), one full period lasts 2P clocks. The sync pulse is high for one cycle at each period start. Over 100 cycles with P=10, it occurs exactly 5 times.
- R3: A phase whose effective duty is D drives its high side for 2D consecutive cycles per period, centred on the timer turnaround, and its low side for the remaining cycles. D=0 gives a phase that is fully off. D>=P gives a phase that is fully on.
- R4: When control bit 11 is 0 (single update), new duty values and a new period take effect only at the next period start.
- R5: When control bit 11 is 1 (double update), new duty values also take effect at the period midpoint.
- R6: The dead time T (address 1) holds a gate off until its complementary signal has been off for T cycles. With P=10, D=2 and T=2, the high side is on for 2 cycles per period and the low side for 14.
- R7: With deletion width W (address 2), a duty D<W is treated as 0 and a duty with P-D<W is treated as P.
- R8: Control bits 0..2 enable the high-side gates of A, B and C. Bits 3..5 enable the low-side gates of A, B and C. A disabled gate stays low.
- R9: Control bits 6..8 swap the high-side and low-side signals of phase A, B and C respectively.
- R10: Control bit 9 gates all high-side outputs with the chopping carrier, and bit 10 gates all low-side outputs with it. The carrier toggles every K+1 clocks, where K is written at address 7.
- R11: While trip is high, all six gates are low in the same cycle. After trip falls, they stay low until the control word (address 6) is written with trip low.
- R12: The high-side and low-side gates of one phase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 dead time, 2 deletion, 3..5 duty A..C, 6 control, 7 chop divider) |
| wr_data | input | 16 | Register write data |
| trip | input | 1 | Fault input, forces every gate off |
| sync_pulse | output | 1 | One-cycle pulse at each period start |
| gate_hi | output | 3 | High-side gates, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gates, bit 0 = phase A |

## Verification
A timer that loses its place shows up within one period in two ways: the sync pulse arrives at the wrong spacing, and the gate edges are no longer symmetric about the turnaround. A duty value latched at the wrong time shows as a pulse width that is wrong for one half-period, so each update mode is stressed by writes made mid-period. Faults in the dead-time run counter or in the deletion clamp change the on-count of a gate within one period. A trip latch that clears too early lets a gate go high in the cycles just after trip falls.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int ADDR_W = 3;
  localparam int NPH    = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PER  = 3'd0,
    A_DEAD = 3'd1,
    A_DEL  = 3'd2,
    A_DA   = 3'd3,
    A_DB   = 3'd4,
    A_DC   = 3'd5,
    A_CTRL = 3'd6,
    A_CHOP = 3'd7
  } reg_addr_e;

  // Control word, LSB first: en_hi[2:0], en_lo[5:3], swap[8:6], chop_hi 9, chop_lo 10, dbl 11
  typedef struct packed {
    logic           dbl;
    logic           chop_lo;
    logic           chop_hi;
    logic [NPH-1:0] swap;
    logic [NPH-1:0] en_lo;
    logic [NPH-1:0] en_hi;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] per_shd,
  input  logic         dbl,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         running,
  output logic         load,
  output logic [W-1:0] per_use,
  output logic [W-1:0] act_per,
  output logic         sync_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         load_s, load_m;
  logic [W-1:0] per_raw;

  assign load_s  = running & up & (cnt == '0);
  assign load_m  = running & dbl & ~up & (cnt == act_per);
  assign load    = load_s | load_m;
  assign per_raw = load_s ? per_shd : act_per;
  assign per_use = (per_raw == '0) ? ONE : per_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      up      <= 1'b1;
      running <= 1'b0;
      act_per <= '0;
      sync_q  <= 1'b0;
    end else begin
      sync_q <= load_s;
      if (!running) begin
        running <= start;
        cnt     <= '0;
        up      <= 1'b1;
      end else begin
        act_per <= per_use;
        if (up) begin
          if (cnt == per_use - ONE) begin
            up  <= 1'b0;
            cnt <= per_use;
          end else begin
            cnt <= cnt + ONE;
          end
        end else if (cnt <= ONE) begin
          up  <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         running,
  input  logic         load,
  input  logic         up,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per_use,
  input  logic [W-1:0] duty_shd,
  input  logic [W-1:0] del_w,
  input  logic [W-1:0] dead_w,
  output logic         hi_dt,
  output logic         lo_dt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] act_duty, duty_use, eff, run_q, run_now;
  logic [W:0]   sum;
  logic         on, ideal_q, prev_q;

  assign duty_use = load ? duty_shd : act_duty;

  always_comb begin
    if (duty_use >= per_use)           eff = per_use;
    else if (duty_use < del_w)         eff = '0;
    else if (per_use - duty_use < del_w) eff = per_use;
    else                               eff = duty_use;
  end

  assign sum = {1'b0, cnt} + {1'b0, eff};
  assign on  = up ? (sum >= {1'b0, per_use}) : (sum > {1'b0, per_use});

  assign run_now = (ideal_q != prev_q) ? ONE : ((run_q == '1) ? run_q : run_q + ONE);
  assign hi_dt   =  ideal_q & (run_now > dead_w);
  assign lo_dt   = ~ideal_q & (run_now > dead_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_duty <= '0;
      ideal_q  <= 1'b0;
      prev_q   <= 1'b0;
      run_q    <= '0;
    end else begin
      act_duty <= duty_use;
      ideal_q  <= running & on;
      prev_q   <= ideal_q;
      run_q    <= run_now;
    end
  end
endmodule

// File: rtl/pwm3_chop.sv
module pwm3_chop #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] div,
  output logic         carrier
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      carrier <= 1'b0;
    end else if (cnt_q >= div) begin
      cnt_q   <= '0;
      carrier <= ~carrier;
    end else begin
      cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
  import pwm3_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              trip,
  output logic              sync_pulse,
  output logic [NPH-1:0]    gate_hi,
  output logic [NPH-1:0]    gate_lo
);
  logic [W-1:0] per_r, dead_r, del_r, chopd_r;
  logic [W-1:0] duty_r [NPH];
  ctrl_t        ctrl_r;
  logic         tripped_q, start, carrier;
  logic         running, load, up;
  logic [W-1:0] cnt, per_use, act_per;
  logic [NPH-1:0] hi_dt, lo_dt, gate_hi_q, gate_lo_q;

  assign start = wr_en & ((wr_addr == A_DA) | (wr_addr == A_DB) | (wr_addr == A_DC));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_r   <= '0;
      dead_r  <= '0;
      del_r   <= '0;
      chopd_r <= '0;
      ctrl_r  <= '0;
      for (int i = 0; i < NPH; i++) duty_r[i] <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_PER:   per_r     <= wr_data;
        A_DEAD:  dead_r    <= wr_data;
        A_DEL:   del_r     <= wr_data;
        A_DA:    duty_r[0] <= wr_data;
        A_DB:    duty_r[1] <= wr_data;
        A_DC:    duty_r[2] <= wr_data;
        A_CTRL:  ctrl_r    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default: chopd_r   <= wr_data;
      endcase
    end
  end

  pwm3_timer #(.W(W)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .per_shd(per_r), .dbl(ctrl_r.dbl),
    .cnt(cnt), .up(up), .running(running), .load(load), .per_use(per_use),
    .act_per(act_per), .sync_q(sync_pulse)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    pwm3_phase #(.W(W)) u_ph (
      .clk(clk), .rst(rst), .running(running), .load(load), .up(up), .cnt(cnt),
      .per_use(per_use), .duty_shd(duty_r[g]), .del_w(del_r), .dead_w(dead_r),
      .hi_dt(hi_dt[g]), .lo_dt(lo_dt[g])
    );
  end

  pwm3_chop #(.W(W)) u_chop (.clk(clk), .rst(rst), .div(chopd_r), .carrier(carrier));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi_q <= '0;
      gate_lo_q <= '0;
      tripped_q <= 1'b0;
    end else begin
      for (int i = 0; i < NPH; i++) begin
        gate_hi_q[i] <= running & ctrl_r.en_hi[i] & (~ctrl_r.chop_hi | carrier) &
                        (ctrl_r.swap[i] ? lo_dt[i] : hi_dt[i]);
        gate_lo_q[i] <= running & ctrl_r.en_lo[i] & (~ctrl_r.chop_lo | carrier) &
                        (ctrl_r.swap[i] ? hi_dt[i] : lo_dt[i]);
      end
      if (trip)                                 tripped_q <= 1'b1;
      else if (wr_en && (wr_addr == A_CTRL))    tripped_q <= 1'b0;
    end
  end

  assign gate_hi = gate_hi_q & {NPH{~(trip | tripped_q)}};
  assign gate_lo = gate_lo_q & {NPH{~(trip | tripped_q)}};
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk
  import pwm3_pkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           trip,
  input logic           sync_pulse,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic           running,
  input logic [W-1:0]   cnt,
  input logic [W-1:0]   act_per
);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0);

  assert_trip_now_R11: assert property (@(posedge clk) disable iff (rst)
    trip |-> (gate_hi == '0 && gate_lo == '0));

  assert_trip_hold_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(trip) && !$past(rst)) |-> (gate_hi == '0 && gate_lo == '0));

  assert_idle_off_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> (gate_hi == '0 && gate_lo == '0 && !sync_pulse));

  assert_run_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt <= act_per));
endmodule

bind pwm3_top pwm3_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .trip(trip), .sync_pulse(sync_pulse),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .running(running),
  .cnt(cnt), .act_per(act_per)
);

// File: tb/sim_pwm3_top.sv
module sim_pwm3_top;
  localparam int W    = 16;
  localparam int MAXV = (1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip = 1'b0;
  logic        sync_pulse;
  logic [2:0]  gate_hi, gate_lo;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  pwm3_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip(trip), .sync_pulse(sync_pulse), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #10 clk = ~clk;

  // Behavioural reference: position t within a 2P-cycle period
  int m_run, m_t, m_P, m_trp, m_chc, m_car;
  int m_D [3];
  int m_len [3];
  int sh_P, sh_DT, sh_PD, sh_chd;
  int sh_D [3];
  bit [11:0] sh_ctrl;
  bit [2:0] m_ideal, m_prev, m_gh, m_gl;
  bit m_sync;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_t = 0; m_P = 0; m_trp = 0; m_chc = 0; m_car = 0;
      sh_P = 0; sh_DT = 0; sh_PD = 0; sh_chd = 0; sh_ctrl = '0;
      m_ideal = '0; m_prev = '0; m_gh = '0; m_gl = '0; m_sync = 0;
      for (int i = 0; i < 3; i++) begin m_D[i] = 0; m_len[i] = 0; sh_D[i] = 0; end
    end else begin
      int Puse;
      bit ld_s, ld_m;
      bit [2:0] nid, ngh, ngl;
      int nlen [3];
      for (int i = 0; i < 3; i++) begin
        int rn;
        bit hd, lw, h, l;
        rn = (m_ideal[i] == m_prev[i]) ? ((m_len[i] >= MAXV) ? MAXV : m_len[i] + 1) : 1;
        hd = m_ideal[i] && (rn > sh_DT);
        lw = !m_ideal[i] && (rn > sh_DT);
        h = sh_ctrl[6+i] ? lw : hd;
        l = sh_ctrl[6+i] ? hd : lw;
        h = h && sh_ctrl[i] && (!sh_ctrl[9] || m_car != 0) && m_run != 0;
        l = l && sh_ctrl[3+i] && (!sh_ctrl[10] || m_car != 0) && m_run != 0;
        ngh[i] = h; ngl[i] = l; nlen[i] = rn;
      end
      ld_s = (m_run != 0) && (m_t == 0);
      ld_m = (m_run != 0) && sh_ctrl[11] && (m_t == m_P);
      Puse = ld_s ? sh_P : m_P;
      if (Puse == 0) Puse = 1;
      for (int i = 0; i < 3; i++) begin
        int du, e;
        du = (ld_s || ld_m) ? sh_D[i] : m_D[i];
        if (du >= Puse) e = Puse;
        else if (du < sh_PD) e = 0;
        else if (Puse - du < sh_PD) e = Puse;
        else e = du;
        nid[i] = (m_run != 0) && (m_t >= Puse - e) && (m_t < Puse + e);
        m_D[i] = du;
      end
      m_prev = m_ideal; m_ideal = nid; m_gh = ngh; m_gl = ngl; m_sync = ld_s;
      for (int i = 0; i < 3; i++) m_len[i] = nlen[i];
      if (m_run != 0) begin m_P = Puse; m_t = (m_t + 1) % (2 * Puse); end
      if (m_chc >= sh_chd) begin m_chc = 0; m_car = 1 - m_car; end
      else m_chc = m_chc + 1;
      if (trip) m_trp = 1;
      else if (wr_en && wr_addr == 3'd6) m_trp = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: sh_P = wr_data;
          3'd1: sh_DT = wr_data;
          3'd2: sh_PD = wr_data;
          3'd3, 3'd4, 3'd5: begin
            sh_D[wr_addr-3] = wr_data;
            if (m_run == 0) begin m_run = 1; m_t = 0; end
          end
          3'd6: sh_ctrl = wr_data[11:0];
          default: sh_chd = wr_data;
        endcase
      end
    end
  end

  // Per-clock comparison against the reference
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      bit [2:0] eh, el;
      eh = m_gh & {3{!(trip || m_trp != 0)}};
      el = m_gl & {3{!(trip || m_trp != 0)}};
      total++;
      if (gate_hi !== eh || gate_lo !== el || sync_pulse !== m_sync) begin
        bad++;
        $display("FAIL %s cyc=%0d hi=%b exp=%b lo=%b exp=%b sync=%b exp=%b",
                 cur_req, cyc, gate_hi, eh, gate_lo, el, sync_pulse, m_sync);
      end
      total++;
      if ((gate_hi & gate_lo) !== 3'b000) begin
        bad++;
        $display("FAIL R12 cyc=%0d hi=%b lo=%b expected no common bit", cyc, gate_hi, gate_lo);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL watchdog all requirements actual=%0d cycles expected<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts high cycles of each output over n samples
  int c_hi [3];
  int c_lo [3];
  int c_sy;
  task automatic count(input int n);
    c_sy = 0;
    for (int i = 0; i < 3; i++) begin c_hi[i] = 0; c_lo[i] = 0; end
    repeat (n) begin
      @(posedge clk); #5;
      c_sy += int'(sync_pulse);
      for (int i = 0; i < 3; i++) begin
        c_hi[i] += int'(gate_hi[i]);
        c_lo[i] += int'(gate_lo[i]);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    check("R1 reset gates", int'({gate_hi, gate_lo}), 0);
    check("R1 reset sync", int'(sync_pulse), 0);

    cur_req = "R1";
    wr(6, 16'h003F);
    wr(0, 10);
    count(20);
    check("R1 stopped hi A", c_hi[0], 0);
    check("R1 stopped lo A", c_lo[0], 0);
    check("R1 stopped sync", c_sy, 0);

    cur_req = "R2";
    wr(3, 3); wr(4, 0); wr(5, 10);
    idle(60);
    count(100);
    check("R2 sync per 100", c_sy, 5);
    cur_req = "R3";
    count(20);
    check("R3 hi A D=3", c_hi[0], 6);
    check("R3 lo A D=3", c_lo[0], 14);
    check("R3 hi B D=0", c_hi[1], 0);
    check("R3 lo B D=0", c_lo[1], 20);
    check("R3 hi C D=P", c_hi[2], 20);
    check("R3 lo C D=P", c_lo[2], 0);

    cur_req = "R4";
    idle(7);
    wr(3, 7);
    idle(50);
    count(20);
    check("R4 hi A D=7", c_hi[0], 14);

    cur_req = "R5";
    wr(6, 16'h083F);
    idle(13);
    wr(3, 2);
    idle(60);
    count(20);
    check("R5 hi A D=2", c_hi[0], 4);

    cur_req = "R6";
    wr(1, 2);
    idle(60);
    count(20);
    check("R6 hi A dead", c_hi[0], 2);
    check("R6 lo A dead", c_lo[0], 14);

    cur_req = "R7";
    wr(2, 3); wr(3, 2); wr(4, 8); wr(5, 5);
    idle(60);
    count(20);
    check("R7 hi A deleted", c_hi[0], 0);
    check("R7 hi B widened", c_hi[1], 20);
    check("R7 hi C normal", c_hi[2], 8);

    cur_req = "R8";
    wr(6, 16'h0811);
    idle(40);
    count(20);
    check("R8 hi B off", c_hi[1], 0);
    check("R8 hi C off", c_hi[2], 0);
    check("R8 lo A off", c_lo[0], 0);
    check("R8 lo C off", c_lo[2], 0);
    check("R8 lo B on", c_lo[1], 0);

    cur_req = "R9";
    wr(2, 0); wr(1, 0); wr(3, 3); wr(5, 10);
    wr(6, 16'h007F);
    idle(50);
    count(20);
    check("R9 lo A swapped", c_lo[0], 6);
    check("R9 hi A swapped", c_hi[0], 14);

    cur_req = "R10";
    wr(7, 1);
    wr(6, 16'h023F);
    idle(60);
    count(20);
    check("R10 hi C chopped", c_hi[2], 10);
    check("R10 lo A unchopped", c_lo[0], 14);

    cur_req = "R11";
    @(negedge clk);
    trip = 1'b1;
    #1;
    check("R11 trip immediate", int'({gate_hi, gate_lo}), 0);
    idle(3);
    trip = 1'b0;
    count(8);
    check("R11 latched hi C", c_hi[2], 0);
    check("R11 latched lo A", c_lo[0], 0);
    wr(6, 16'h003F);
    idle(30);
    count(20);
    check("R11 cleared hi C", c_hi[2], 20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule